// File: doc/BRIEF.md
# Change-Triggered DAC Update Request Generator

This block sits in front of a serial DAC transmitter. It keeps the DAC output in step with the application's data without manual update strobes and without continuous retransmission. For every channel it registers the last code and the last power-mode setting. If the current inputs differ from the registered copy in any bit, it raises an update request. The request stays high until the transmitter drives its frame-sync signal high to show that a frame carrying the new data has started. The request then drops.

The number of channels is a parameter. With one channel the block serves a single converter. With two channels, which is the default, it watches both converters of a dual module and produces one shared request. A change on any channel sets that request. If a change arrives in the same cycle as the sync clear, the request stays set, so a fresh value is never left unsent. The block does not perform the serial transfer.

Top module: `dac_change_req`

## Requirements
- R1: While rst_n is low, upd_o is 0 one clock edge later. Reset also loads the compare registers with the inputs present, so releasing reset with unchanged inputs leaves upd_o at 0.
- R2: If any bit of a channel's code differs from the value sampled at the previous clock edge, upd_o is 1 after the edge that sees the difference.
- R3: If any bit of a channel's 2-bit power-mode field differs from the value sampled at the previous edge, upd_o is 1 after that edge. The field is passed through unchanged: 0 normal, 1 1 kΩ to ground, 2 100 kΩ to ground, 3 high impedance.
- R4: With no input change and sync_i low, upd_o keeps its value across an edge.
- R5: With no input change, sync_i high at an edge clears upd_o to 0.
- R6: An input change at an edge where sync_i is high leaves upd_o at 1, whether upd_o was 0 or 1 before.
- R7: Channel k's code occupies val_i[k*12 +: 12] and its mode occupies mode_i[k*2 +: 2]. A change on any channel alone, or on several channels at once, sets the single shared upd_o.
- R8: With no input change and upd_o low, upd_o stays 0 whatever the value of sync_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_i | input | 1 | Frame-sync from the transmitter; high clears the request |
| val_i | input | NUM_CH*VAL_W (24) | Channel codes, channel 0 in the low bits |
| mode_i | input | NUM_CH*MODE_W (4) | Channel power-mode fields, channel 0 in the low bits |
| upd_o | output | 1 | Registered update request to the transmitter |

## Verification
The stimulus covers the following input patterns:
- Changes on one field at a time: a channel-0 code, a channel-0 mode, a channel-1 code and a channel-1 mode. This shows that every field reaches the shared request.
- A single least-significant-bit change, which shows that the compare works down to the lowest bit.
- A change on both channels at once.
- A change that coincides with sync, applied both while the request is already pending and while it is idle. This separates the priority of set over clear from a plain clear.
- Long stretches of steady inputs with sync high and with sync low, which expose any spurious request or any failure to hold.
- A reset applied with new inputs in the middle of a pending request. This checks that reset clears the request and loads the compare registers.

// File: rtl/dacreq_pkg.sv
// Package dacreq_pkg
// Holds the default geometry of the request generator and the action
// encoding that the request register uses. No state lives here.
package dacreq_pkg;
    localparam int DEF_NUM_CH = 2;
    localparam int DEF_VAL_W  = 12;
    localparam int DEF_MODE_W = 2;

    // Action applied to the request flop at the next edge.
    typedef enum logic [1:0] {
        REQ_HOLD  = 2'd0,
        REQ_SET   = 2'd1,
        REQ_CLEAR = 2'd2
    } req_act_e;
endpackage

// File: rtl/dacreq_chan_watch.sv
// Module dacreq_chan_watch
// Watches one channel. It registers the channel's code and power mode on
// every clock edge and flags any difference between the live inputs and
// the registered copy.
// Assumption: the inputs are synchronous to clk. During reset the copy
// follows the inputs, so the copy equals the inputs held at reset release.
module dacreq_chan_watch #(
    parameter int VAL_W  = dacreq_pkg::DEF_VAL_W,
    parameter int MODE_W = dacreq_pkg::DEF_MODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VAL_W-1:0]  val_i,
    input  logic [MODE_W-1:0] mode_i,
    output logic              chg_o
);
    localparam int SNAP_W = VAL_W + MODE_W;

    logic [SNAP_W-1:0] live;
    logic [SNAP_W-1:0] snap_q;

    assign live = {val_i, mode_i};

    // Capture the channel inputs every edge; reset loads the same live inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) snap_q <= live;
        else        snap_q <= live;
    end

    // Flag any bit difference against the previous sample.
    always_comb chg_o = (live != snap_q);
endmodule

// File: rtl/dacreq_req_reg.sv
// Module dacreq_req_reg
// Holds the update request. A change sets it. A sync with no change
// clears it. Otherwise it holds. Set has priority over clear, so a change
// that coincides with a sync is never dropped.
// Assumption: sync_i is synchronous to clk.
module dacreq_req_reg
    import dacreq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_chg_i,
    input  logic sync_i,
    output logic upd_o
);
    req_act_e act;

    // Choose the action for the next edge; set wins over clear.
    always_comb begin
        if (any_chg_i)   act = REQ_SET;
        else if (sync_i) act = REQ_CLEAR;
        else             act = REQ_HOLD;
    end

    // Apply the chosen action; reset drops the request.
    always_ff @(posedge clk) begin
        if (!rst_n) upd_o <= 1'b0;
        else begin
            case (act)
                REQ_SET:   upd_o <= 1'b1;
                REQ_CLEAR: upd_o <= 1'b0;
                default:   upd_o <= upd_o;
            endcase
        end
    end
endmodule

// File: rtl/dac_change_req.sv
// Module dac_change_req
// Top level. It instantiates one watcher per channel, ORs their change
// flags and drives one shared, registered update request that the
// transmitter's sync clears.
// Assumption: channel k occupies the k-th slice of val_i and mode_i.
module dac_change_req #(
    parameter int NUM_CH = dacreq_pkg::DEF_NUM_CH,
    parameter int VAL_W  = dacreq_pkg::DEF_VAL_W,
    parameter int MODE_W = dacreq_pkg::DEF_MODE_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sync_i,
    input  logic [NUM_CH*VAL_W-1:0]  val_i,
    input  logic [NUM_CH*MODE_W-1:0] mode_i,
    output logic                     upd_o
);
    logic [NUM_CH-1:0] chg;
    logic              any_chg;

    // One watcher per channel.
    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        dacreq_chan_watch #(.VAL_W(VAL_W), .MODE_W(MODE_W)) watch_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .val_i  (val_i[k*VAL_W +: VAL_W]),
            .mode_i (mode_i[k*MODE_W +: MODE_W]),
            .chg_o  (chg[k])
        );
    end

    // Combine the per-channel flags into one set condition.
    always_comb any_chg = |chg;

    dacreq_req_reg req_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_chg_i (any_chg),
        .sync_i    (sync_i),
        .upd_o     (upd_o)
    );
endmodule

// File: rtl/dac_change_req_chk.sv
// Module dac_change_req_chk
// Checker bound to dac_change_req. It keeps its own copy of the inputs
// from the previous edge and checks the request at the ports.
module dac_change_req_chk #(
    parameter int NUM_CH = 2,
    parameter int VAL_W  = 12,
    parameter int MODE_W = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     sync_i,
    input logic [NUM_CH*VAL_W-1:0]  val_i,
    input logic [NUM_CH*MODE_W-1:0] mode_i,
    input logic                     upd_o
);
    logic [NUM_CH*(VAL_W+MODE_W)-1:0] seen_q;
    logic                             moved;

    // Keep the checker's own copy of the inputs from the last edge.
    always_ff @(posedge clk) seen_q <= {val_i, mode_i};

    // Detect an input difference against that copy.
    always_comb moved = ({val_i, mode_i} != seen_q);

    // R1
    reset_clear_chk: assert property (@(posedge clk) !rst_n |=> !upd_o);

    // R2
    change_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        moved |=> upd_o);

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_o && !moved && !sync_i) |=> upd_o);

    // R5
    sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_o && !moved && sync_i) |=> !upd_o);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_o && !moved) |=> !upd_o);
endmodule

bind dac_change_req dac_change_req_chk #(
    .NUM_CH(NUM_CH), .VAL_W(VAL_W), .MODE_W(MODE_W)
) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .sync_i (sync_i),
    .val_i  (val_i),
    .mode_i (mode_i),
    .upd_o  (upd_o)
);

// File: tb/dac_change_req_tb.sv
module dac_change_req_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_i = 1'b0;
    logic [23:0] val_i = {12'h200, 12'h100};
    logic [3:0]  mode_i = 4'h0;
    logic        upd_o;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    dac_change_req dut_i (
        .clk(clk), .rst_n(rst_n), .sync_i(sync_i),
        .val_i(val_i), .mode_i(mode_i), .upd_o(upd_o)
    );

    // Vector fields: {sync, v0, m0, v1, m1, expected upd}
    localparam int NV = 20;
    localparam logic [29:0] VEC [NV] = '{
        {1'b0, 12'h100, 2'd0, 12'h200, 2'd0, 1'b0},  // R8 steady
        {1'b0, 12'h123, 2'd0, 12'h200, 2'd0, 1'b1},  // R2 ch0 code
        {1'b0, 12'h123, 2'd0, 12'h200, 2'd0, 1'b1},  // R4 hold
        {1'b1, 12'h123, 2'd0, 12'h200, 2'd0, 1'b0},  // R5 clear
        {1'b1, 12'h123, 2'd0, 12'h200, 2'd0, 1'b0},  // R8 sync idle
        {1'b0, 12'h123, 2'd2, 12'h200, 2'd0, 1'b1},  // R3 ch0 mode
        {1'b1, 12'h123, 2'd2, 12'h200, 2'd0, 1'b0},  // R5
        {1'b0, 12'h123, 2'd2, 12'h2AB, 2'd0, 1'b1},  // R7 ch1 code
        {1'b1, 12'h123, 2'd2, 12'h2AB, 2'd3, 1'b1},  // R6 pending + sync
        {1'b1, 12'h123, 2'd2, 12'h2AB, 2'd3, 1'b0},  // R5
        {1'b0, 12'h123, 2'd2, 12'h2AB, 2'd3, 1'b0},  // R8
        {1'b1, 12'hFFF, 2'd2, 12'h2AB, 2'd3, 1'b1},  // R6 idle + sync
        {1'b0, 12'hFFF, 2'd2, 12'h2AB, 2'd3, 1'b1},  // R4
        {1'b0, 12'hFFF, 2'd2, 12'h2AB, 2'd3, 1'b1},  // R4
        {1'b1, 12'hFFF, 2'd2, 12'h2AB, 2'd3, 1'b0},  // R5
        {1'b0, 12'h000, 2'd1, 12'h000, 2'd1, 1'b1},  // R7 both channels
        {1'b1, 12'h000, 2'd1, 12'h000, 2'd1, 1'b0},  // R5
        {1'b0, 12'h001, 2'd1, 12'h000, 2'd1, 1'b1},  // R2 lsb
        {1'b1, 12'h001, 2'd1, 12'h000, 2'd1, 1'b0},  // R5
        {1'b0, 12'h001, 2'd1, 12'h000, 2'd1, 1'b0}   // R8
    };

    task automatic check(input string req, input logic exp);
        n_run++;
        if (upd_o !== exp) begin
            n_fail++;
            $display("FAIL %s: upd_o=%b expected %b at %0t", req, upd_o, exp, $time);
        end
    endtask

    // Drive at a falling edge, then sample at the next falling edge.
    task automatic step(input logic s, input logic [11:0] v0, input logic [1:0] m0,
                        input logic [11:0] v1, input logic [1:0] m1);
        sync_i = s;
        val_i  = {v1, v0};
        mode_i = {m1, m0};
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", 1'b0);                   // in reset
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][29], VEC[i][28:17], VEC[i][16:15], VEC[i][14:3], VEC[i][2:1]);
            check($sformatf("vec%0d R2-group", i), VEC[i][0]);
        end
        // Directed: reset with a pending request and new inputs.
        step(1'b0, 12'h555, 2'd1, 12'h000, 2'd1);
        check("R2", 1'b1);
        rst_n = 1'b0;
        step(1'b0, 12'h7AA, 2'd1, 12'h000, 2'd1);
        check("R1", 1'b0);
        rst_n = 1'b1;
        step(1'b0, 12'h7AA, 2'd1, 12'h000, 2'd1);
        check("R1 release", 1'b0);
        step(1'b0, 12'h7AA, 2'd1, 12'h000, 2'd1);
        check("R8", 1'b0);
        step(1'b0, 12'h7AA, 2'd1, 12'h000, 2'd2);
        check("R3 ch1 mode", 1'b1);
        step(1'b0, 12'h7AA, 2'd1, 12'h000, 2'd2);
        check("R4", 1'b1);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule